// File: doc/BRIEF.md
# Active-Rule Fuzzy Inference Core

This core carries out zero-order Takagi-Sugeno fuzzy inference on two 8-bit crisp inputs and returns one 12-bit crisp result. Each input is compared against up to seven trapezoidal fuzzy sets. The core scores how strongly the input belongs to each set. It then picks out, for each input, the sets that score above zero. Only the rules formed from those sets are walked. Each rule's firing strength is the smaller of its two scores. The strength weights a constant consequent read from a 49-entry table. The result is the strength-weighted mean of those consequents.

Software or a neighbouring block fills the set shapes and the consequent table through a small address/data write port while the core is idle. A sample starts on a one-cycle `start` pulse. The answer appears with a one-cycle `out_valid` pulse after a fixed number of cycles. Rule evaluation takes four slots, whatever the size of the rule base, and the weighted mean is produced by a bit-serial divider.

Top module: `fuzzy_ts_core`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_y` is 0, and every set shape and consequent entry is zero, so any sample yields 0.
- R2: The degree of input x in a set with left foot L, right foot H, rise slope S and fall slope F is 0 when x<L or x>H. Otherwise it is min(sat((x-L)*S), sat((H-x)*F)), where sat clips at 255, and 255 means full membership.
- R3: The rule formed by set i of input A and set j of input B reads consequent entry i*7+j.
- R4: For each input, at most the two lowest-numbered sets with a non-zero degree take part. Each of the up to four resulting rules has a strength equal to the minimum of its two degrees.
- R5: The output is floor((Σ strength·consequent + floor(Σ strength / 2)) / Σ strength), which is the weighted mean rounded half up.
- R6: When every strength is zero, the output is 0.
- R7: `out_valid` is high for exactly one cycle. It rises on the 31st rising clock edge counted from, and including, the edge that samples `start`.
- R8: A `start` pulse that arrives while a sample is in progress has no effect. The running sample finishes with its own result, and no extra result is produced.
- R9: Parameter writes issued while a sample is in progress are discarded.
- R10: The write port decodes addresses as follows. With `cfg_addr[7]`=0, bit 6 picks the input (0 = A, 1 = B), bits 4:2 pick the set (0..6), and bits 1:0 pick the field (0 = left foot, 1 = right foot, 2 = rise slope, 3 = fall slope), each taking `cfg_data[7:0]`. With `cfg_addr[7]`=1, bits 5:0 pick a consequent entry (0..48), which takes all 12 data bits. Set numbers above 6 and entries above 48 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to process the current input pair |
| in_a | input | 8 | Crisp input A, sampled with `start` |
| in_b | input | 8 | Crisp input B, sampled with `start` |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_addr | input | 8 | Parameter address |
| cfg_data | input | 12 | Parameter write data |
| out_valid | output | 1 | One-cycle result strobe |
| out_y | output | 12 | Crisp output, held until the next result |

## Verification
Some properties are checked by assertions on every cycle:
- the result strobe lasts one cycle and always follows the final divider step;
- a zero weight sum gives a zero output;
- the four rule slots are stepped in order;
- the selected sets carry non-zero degrees and appear in ascending set order.

Other behaviour can only be shown by the bench's scenarios, which compare against an independent model for several input pairs:
- the degree arithmetic with its saturation;
- the rule-to-consequent mapping;
- rounding;
- the fixed latency;
- immunity to starts and writes that arrive mid-sample.

// File: rtl/fuzzy_ts_core.sv
module fuzzy_ts_core #(
  parameter int IN_W   = 8,
  parameter int DEG_W  = 8,
  parameter int CONS_W = 12,
  parameter int OUT_W  = 12,
  parameter int NSETS  = 7,
  parameter int CFG_AW = 8,
  parameter int CFG_DW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IN_W-1:0]   in_a,
  input  logic [IN_W-1:0]   in_b,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_data,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_y
);
  localparam int SW      = $clog2(NSETS);
  localparam int NRULES  = NSETS * NSETS;
  localparam int RW      = $clog2(NRULES);
  localparam int PW      = IN_W + DEG_W;
  localparam int DEN_W   = DEG_W + 2;
  localparam int NUM_W   = DEG_W + CONS_W + 3;
  localparam int CW      = $clog2(NUM_W);
  localparam int DEG_MAX = (1 << DEG_W) - 1;

  typedef enum logic [2:0] {S_IDLE, S_FUZ, S_SEL, S_RULE, S_PREP, S_DIV} st_t;
  st_t state;

  logic [IN_W-1:0]   lo_q [2][NSETS];
  logic [IN_W-1:0]   hi_q [2][NSETS];
  logic [DEG_W-1:0]  sr_q [2][NSETS];
  logic [DEG_W-1:0]  sf_q [2][NSETS];
  logic [CONS_W-1:0] cons_q [NRULES];

  logic [IN_W-1:0]   xa_q, xb_q;
  logic [DEG_W-1:0]  deg_q [2][NSETS];
  logic              pick_v [2][2];
  logic [SW-1:0]     pick_i [2][2];
  logic [DEG_W-1:0]  pick_d [2][2];
  logic              sel_v [2][2];
  logic [SW-1:0]     sel_i [2][2];
  logic [DEG_W-1:0]  sel_d [2][2];
  logic [1:0]        rk;
  logic [NUM_W-1:0]  num_acc, dvd;
  logic [DEN_W-1:0]  den_acc, rem;
  logic [CW-1:0]     cnt;

  function automatic logic [DEG_W-1:0] mf_deg(input logic [IN_W-1:0] x, lo, hi,
                                              input logic [DEG_W-1:0] sr, sf);
    logic [PW-1:0] r, f;
    logic [DEG_W-1:0] rs, fs;
    r  = {{DEG_W{1'b0}}, IN_W'(x - lo)} * {{IN_W{1'b0}}, sr};
    f  = {{DEG_W{1'b0}}, IN_W'(hi - x)} * {{IN_W{1'b0}}, sf};
    rs = (r > PW'(DEG_MAX)) ? '1 : r[DEG_W-1:0];
    fs = (f > PW'(DEG_MAX)) ? '1 : f[DEG_W-1:0];
    if (x < lo || x > hi) return '0;
    return (rs < fs) ? rs : fs;
  endfunction

  // configuration write decode
  wire              idle    = (state == S_IDLE);
  wire              is_cons = cfg_addr[CFG_AW-1];
  wire              cf_in   = cfg_addr[CFG_AW-2];
  wire [SW-1:0]     cf_set  = cfg_addr[SW+1:2];
  wire [1:0]        cf_fld  = cfg_addr[1:0];
  wire [RW-1:0]     cf_idx  = cfg_addr[RW-1:0];
  wire [IN_W-1:0]   cf_byte = cfg_data[IN_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < 2; n++)
        for (int s = 0; s < NSETS; s++) begin
          lo_q[n][s] <= '0; hi_q[n][s] <= '0;
          sr_q[n][s] <= '0; sf_q[n][s] <= '0;
        end
      for (int r = 0; r < NRULES; r++) cons_q[r] <= '0;
    end else if (cfg_we && idle) begin
      if (is_cons) begin
        if (int'(cf_idx) < NRULES) cons_q[cf_idx] <= cfg_data[CONS_W-1:0];
      end else if (int'(cf_set) < NSETS) begin
        case (cf_fld)
          2'd0: lo_q[cf_in][cf_set] <= cf_byte;
          2'd1: hi_q[cf_in][cf_set] <= cf_byte;
          2'd2: sr_q[cf_in][cf_set] <= cf_byte[DEG_W-1:0];
          default: sf_q[cf_in][cf_set] <= cf_byte[DEG_W-1:0];
        endcase
      end
    end
  end

  // lowest two active sets per input
  always_comb begin
    for (int n = 0; n < 2; n++) begin
      for (int k = 0; k < 2; k++) begin
        pick_v[n][k] = 1'b0; pick_i[n][k] = '0; pick_d[n][k] = '0;
      end
      for (int s = 0; s < NSETS; s++) begin
        if (deg_q[n][s] != '0) begin
          if (!pick_v[n][0]) begin
            pick_v[n][0] = 1'b1; pick_i[n][0] = SW'(s); pick_d[n][0] = deg_q[n][s];
          end else if (!pick_v[n][1]) begin
            pick_v[n][1] = 1'b1; pick_i[n][1] = SW'(s); pick_d[n][1] = deg_q[n][s];
          end
        end
      end
    end
  end

  // current rule slot
  wire               ra_v  = sel_v[0][rk[1]];
  wire               rb_v  = sel_v[1][rk[0]];
  wire [DEG_W-1:0]   ra_d  = sel_d[0][rk[1]];
  wire [DEG_W-1:0]   rb_d  = sel_d[1][rk[0]];
  wire [DEG_W-1:0]   w     = (ra_v && rb_v) ? ((ra_d < rb_d) ? ra_d : rb_d) : '0;
  wire [RW-1:0]      r_idx = RW'(sel_i[0][rk[1]]) * RW'(NSETS) + RW'(sel_i[1][rk[0]]);
  wire [CONS_W-1:0]  r_c   = cons_q[r_idx];
  wire [NUM_W-1:0]   r_p   = NUM_W'(w) * NUM_W'(r_c);

  // restoring divider step
  wire [DEN_W:0]     trial = {rem, dvd[NUM_W-1]};
  wire [DEN_W:0]     diff  = trial - {1'b0, den_acc};
  wire               ge    = (trial >= {1'b0, den_acc});
  wire [NUM_W-1:0]   q_nx  = {dvd[NUM_W-2:0], ge};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; xa_q <= '0; xb_q <= '0; rk <= '0;
      num_acc <= '0; den_acc <= '0; dvd <= '0; rem <= '0; cnt <= '0;
      out_valid <= 1'b0; out_y <= '0;
      for (int n = 0; n < 2; n++) begin
        for (int s = 0; s < NSETS; s++) deg_q[n][s] <= '0;
        for (int k = 0; k < 2; k++) begin
          sel_v[n][k] <= 1'b0; sel_i[n][k] <= '0; sel_d[n][k] <= '0;
        end
      end
    end else begin
      out_valid <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          xa_q <= in_a; xb_q <= in_b; state <= S_FUZ;
        end
        S_FUZ: begin
          for (int s = 0; s < NSETS; s++) begin
            deg_q[0][s] <= mf_deg(xa_q, lo_q[0][s], hi_q[0][s], sr_q[0][s], sf_q[0][s]);
            deg_q[1][s] <= mf_deg(xb_q, lo_q[1][s], hi_q[1][s], sr_q[1][s], sf_q[1][s]);
          end
          state <= S_SEL;
        end
        S_SEL: begin
          for (int n = 0; n < 2; n++)
            for (int k = 0; k < 2; k++) begin
              sel_v[n][k] <= pick_v[n][k]; sel_i[n][k] <= pick_i[n][k]; sel_d[n][k] <= pick_d[n][k];
            end
          rk <= '0; num_acc <= '0; den_acc <= '0;
          state <= S_RULE;
        end
        S_RULE: begin
          num_acc <= num_acc + r_p;
          den_acc <= den_acc + DEN_W'(w);
          rk <= rk + 2'd1;
          if (rk == 2'd3) state <= S_PREP;
        end
        S_PREP: begin
          dvd <= num_acc + NUM_W'(den_acc >> 1);
          rem <= '0; cnt <= '0;
          state <= S_DIV;
        end
        S_DIV: begin
          rem <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
          dvd <= q_nx;
          cnt <= cnt + 1'b1;
          if (int'(cnt) == NUM_W - 1) begin
            out_y <= (den_acc == '0) ? '0 :
                     (|q_nx[NUM_W-1:OUT_W]) ? '1 : q_nx[OUT_W-1:0];
            out_valid <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_valid_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(state) == S_DIV);
  p_zero_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && den_acc == '0) |-> out_y == '0);
  p_rule_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RULE && rk != 2'd3) |=> (state == S_RULE && rk == $past(rk) + 2'd1));
  p_sel_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_v[0][0] |-> sel_d[0][0] != '0) and (sel_v[1][0] |-> sel_d[1][0] != '0));
  p_sel_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_v[0][1] |-> (sel_v[0][0] && sel_i[0][1] > sel_i[0][0])) and
    (sel_v[1][1] |-> (sel_v[1][0] && sel_i[1][1] > sel_i[1][0])));
endmodule

// File: tb/fuzzy_ts_core_tb_top.sv
module fuzzy_ts_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_LAT = 31;  // negedges after the start negedge (R7)

  logic clk = 0, rst_n = 0, start = 0, cfg_we = 0;
  logic [7:0] in_a = 0, in_b = 0, cfg_addr = 0;
  logic [11:0] cfg_data = 0;
  logic out_valid;
  logic [11:0] out_y;
  int checks = 0, failures = 0;
  int sh_lo [2][7], sh_hi [2][7], sh_sr [2][7], sh_sf [2][7], sh_c [49];

  always #(CLK_PERIOD/2) clk = ~clk;

  fuzzy_ts_core dut_i (.clk(clk), .rst_n(rst_n), .start(start), .in_a(in_a), .in_b(in_b),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .out_valid(out_valid), .out_y(out_y));

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  function automatic int deg(int x, int lo, int hi, int sr, int sf);
    int r, f;
    if (x < lo || x > hi) return 0;
    r = (x - lo) * sr; if (r > 255) r = 255;
    f = (hi - x) * sf; if (f > 255) f = 255;
    return (r < f) ? r : f;
  endfunction

  function automatic int model(int a, int b);
    int ia[2], da[2], ib[2], db[2], na, nb, num, den, w, d;
    na = 0; nb = 0; num = 0; den = 0;
    for (int s = 0; s < 7; s++) begin
      d = deg(a, sh_lo[0][s], sh_hi[0][s], sh_sr[0][s], sh_sf[0][s]);
      if (d != 0 && na < 2) begin ia[na] = s; da[na] = d; na++; end
      d = deg(b, sh_lo[1][s], sh_hi[1][s], sh_sr[1][s], sh_sf[1][s]);
      if (d != 0 && nb < 2) begin ib[nb] = s; db[nb] = d; nb++; end
    end
    for (int i = 0; i < na; i++)
      for (int j = 0; j < nb; j++) begin
        w = (da[i] < db[j]) ? da[i] : db[j];
        num += w * sh_c[ia[i] * 7 + ib[j]];
        den += w;
      end
    if (den == 0) return 0;
    return (num + den / 2) / den;
  endfunction

  task automatic wr(int addr, int data);
    @(negedge clk); cfg_we = 1; cfg_addr = 8'(addr); cfg_data = 12'(data);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_mf(int n, int s, int lo, int hi, int sr, int sf);
    int base;
    base = n * 64 + s * 4;
    wr(base, lo); wr(base + 1, hi); wr(base + 2, sr); wr(base + 3, sf);
    sh_lo[n][s] = lo; sh_hi[n][s] = hi; sh_sr[n][s] = sr; sh_sf[n][s] = sf;
  endtask

  task automatic set_cons(int idx, int v);
    wr(128 + idx, v); sh_c[idx] = v;
  endtask

  task automatic run(int a, int b, output int y, output int lat);
    @(negedge clk); in_a = 8'(a); in_b = 8'(b); start = 1;
    @(negedge clk); start = 0; lat = 1;
    while (!out_valid && lat < 100) begin @(negedge clk); lat++; end
    y = out_y;
    @(negedge clk);
    chk("R7 pulse width", int'(out_valid), 0);
  endtask

  task automatic t_reset();
    int y, lat;
    chk("R1 valid at reset", int'(out_valid), 0);
    chk("R1 y at reset", int'(out_y), 0);
    run(100, 100, y, lat);
    chk("R1 empty tables give 0", y, 0);
  endtask

  task automatic t_setup();
    for (int s = 0; s < 7; s++) begin
      set_mf(0, s, s * 32, s * 32 + 63, 8, 8);
      set_mf(1, s, s * 32, s * 32 + 63, 5, 12);
    end
    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 7; j++) set_cons(i * 7 + j, i * 300 + j * 170 + 50);
  endtask

  task automatic t_patterns();
    int y, lat;
    int pa[7] = '{10, 40, 100, 255, 33, 64, 200};
    int pb[7] = '{10, 50, 200, 255, 97, 128, 17};
    for (int k = 0; k < 7; k++) begin
      run(pa[k], pb[k], y, lat);
      chk("R2 R3 R4 R5 weighted mean", y, model(pa[k], pb[k]));
      chk("R7 latency", lat, EXP_LAT);
    end
  endtask

  task automatic t_zero();
    int y, lat;
    run(0, 120, y, lat);
    chk("R6 no active rule", y, 0);
  endtask

  task automatic t_busy_start();
    int y, lat, extra;
    @(negedge clk); in_a = 8'd40; in_b = 8'd50; start = 1;
    @(negedge clk); start = 0; lat = 1;
    while (!out_valid && lat < 100) begin
      if (lat == 5) begin in_a = 8'd200; in_b = 8'd17; start = 1; end
      else start = 0;
      @(negedge clk); lat++;
    end
    y = out_y;
    chk("R8 result of first sample", y, model(40, 50));
    chk("R8 latency kept", lat, EXP_LAT);
    extra = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (out_valid) extra++; end
    chk("R8 no second result", extra, 0);
  endtask

  task automatic t_busy_cfg();
    int y, lat, exp;
    exp = model(40, 50);
    @(negedge clk); in_a = 8'd40; in_b = 8'd50; start = 1;
    @(negedge clk); start = 0; lat = 1;
    while (!out_valid && lat < 100) begin
      cfg_we = (lat == 4); cfg_addr = 8'd128; cfg_data = 12'd4000;
      @(negedge clk); lat++;
    end
    cfg_we = 0;
    y = out_y;
    chk("R9 busy write no effect on sample", y, exp);
    run(40, 50, y, lat);
    chk("R9 busy write discarded", y, exp);
  endtask

  task automatic t_cfg_idle();
    int y, lat;
    set_cons(0, 4000);
    run(40, 50, y, lat);
    chk("R10 consequent write", y, model(40, 50));
    set_mf(1, 1, 20, 90, 200, 3);
    run(40, 50, y, lat);
    chk("R10 shape write", y, model(40, 50));
    wr(128 + 60, 777);
    wr(7 * 4 + 2, 255);
    run(40, 50, y, lat);
    chk("R10 out-of-range ignored", y, model(40, 50));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired got=0 exp=1");
    finish_run();
  end

  initial begin
    for (int n = 0; n < 2; n++)
      for (int s = 0; s < 7; s++) begin sh_lo[n][s] = 0; sh_hi[n][s] = 0; sh_sr[n][s] = 0; sh_sf[n][s] = 0; end
    for (int r = 0; r < 49; r++) sh_c[r] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_patterns();
    t_zero();
    t_busy_start();
    t_busy_cfg();
    t_cfg_idle();
    finish_run();
  end
endmodule